// File: doc/BRIEF.md
# SDRAM Command Protocol Checker

This block is a passive observer placed beside an SDRAM command bus. On every rising clock edge it samples the row strobe, column strobe, write enable, clock enable, bank select and the all-banks address line, decodes the command they form, and compares it with what the protocol allows at that point. It drives nothing onto the bus. Its only output is a vector of sticky error flags, one for each kind of violation.

Internally it keeps an idle/open state for every bank. Each bank also has a countdown that measures how long ago it was activated. A separate flag remembers whether the mode register has been written since reset. From this state it detects five faults: an activate issued before the mode register is programmed, an activate to a bank that is already open, a read or write to a closed bank, a read or write issued too soon after the activate, and a mode register write made under the wrong conditions or followed by anything other than a no-operation. The activate-to-column delay and the bank count are parameters.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded from {ras_n, cas_n, we_n} at each rising edge: 111 no-operation, 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode register write, 110 burst stop.
- R2: An activate seen while the mode register has not been written since reset sets err[0].
- R3: An activate to a bank that is already open sets err[1]. The bank stays open.
- R4: A read or write to a bank that is idle sets err[2].
- R5: A read or write to an open bank sets err[3] when it falls fewer than TRCD clocks after that bank's activate. A column command exactly TRCD or more clocks later sets no flag.
- R6: A mode register write while any bank is open sets err[4].
- R7: A mode register write sets err[5] when cke was low at the previous rising edge.
- R8: When the command in the clock after a mode register write is anything other than a no-operation, err[6] is set.
- R9: A precharge with addr_all low closes the bank on ba. A precharge with addr_all high closes every bank.
- R10: The mode register may be written again at any time. Every rewrite is checked by the rules in R6 to R8, and the programmed state is kept across rewrites.
- R11: Reset clears all error flags, closes every bank and marks the mode register unprogrammed. Once set, an error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; commands are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable as seen on the bus |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | $clog2(NUM_BANKS) | Bank select |
| addr_all | input | 1 | Address line that selects all banks on a precharge |
| err | output | 7 | Sticky violation flags, bit positions as in R2 to R8 |

## Verification
The activate-to-column delay is swept over every gap from one to five clocks, on every bank, with reads and writes taking turns. This places the boundary exactly at TRCD and shows that no bank's counter leaks into another. Each of the eight command codes is placed in the clock after a mode register write, so a no-operation can be told apart from every other code, and reads and writes can be told apart from the rest because they also raise the idle-bank flag. The single-bank and all-bank precharge patterns show which banks close, by re-activating both closed and still-open banks. Mode register writes with an open bank, with cke low one clock before and as rewrites after a precharge separate the three mode rules from one another.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_READ,
        CMD_WRITE,
        CMD_PRE,
        CMD_REF,
        CMD_MRS,
        CMD_BST
    } cmd_e;

    typedef struct packed {
        cmd_e op;
        logic all_banks;
    } cmd_t;

    localparam int ERR_W          = 7;
    localparam int ERR_ACT_NOMODE = 0;
    localparam int ERR_ACT_OPEN   = 1;
    localparam int ERR_COL_IDLE   = 2;
    localparam int ERR_TRCD       = 3;
    localparam int ERR_MRS_OPEN   = 4;
    localparam int ERR_MRS_CKE    = 5;
    localparam int ERR_MRS_NEXT   = 6;

    function automatic cmd_e decode_pins(input logic ras_n, input logic cas_n,
                                         input logic we_n);
        cmd_e c;
        unique case ({ras_n, cas_n, we_n})
            3'b111:  c = CMD_NOP;
            3'b011:  c = CMD_ACT;
            3'b101:  c = CMD_READ;
            3'b100:  c = CMD_WRITE;
            3'b010:  c = CMD_PRE;
            3'b001:  c = CMD_REF;
            3'b000:  c = CMD_MRS;
            default: c = CMD_BST;
        endcase
        return c;
    endfunction

    function automatic logic is_column(input cmd_e c);
        return (c == CMD_READ) || (c == CMD_WRITE);
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic addr_all,
    output cmd_t cmd
);

    cmd_e op;

    always_comb begin
        op            = decode_pins(ras_n, cas_n, we_n);
        cmd.op        = op;
        cmd.all_banks = (op == CMD_PRE) && addr_all;
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int TRCD      = 3,
    localparam int BA_W     = $clog2(NUM_BANKS),
    localparam int CNT_W    = $clog2(TRCD + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  cmd_t            cmd,
    input  logic [BA_W-1:0] bank,
    output logic            any_open,
    output logic            v_act_open,
    output logic            v_col_idle,
    output logic            v_trcd
);

    logic [NUM_BANKS-1:0] open_vec;
    logic [NUM_BANKS-1:0] busy_vec;

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic             open_r;
        logic [CNT_W-1:0] cnt_r;
        logic             hit;

        assign hit = (bank == BA_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                open_r <= 1'b0;
                cnt_r  <= '0;
            end else if (cmd.op == CMD_ACT && hit) begin
                open_r <= 1'b1;
                cnt_r  <= CNT_W'(TRCD - 1);
            end else if (cmd.op == CMD_PRE && (cmd.all_banks || hit)) begin
                open_r <= 1'b0;
                cnt_r  <= '0;
            end else if (cnt_r != '0) begin
                cnt_r <= cnt_r - 1'b1;
            end
        end

        assign open_vec[i] = open_r;
        assign busy_vec[i] = (cnt_r != '0);
    end

    always_comb begin
        any_open   = |open_vec;
        v_act_open = (cmd.op == CMD_ACT) && open_vec[bank];
        v_col_idle = is_column(cmd.op) && !open_vec[bank];
        v_trcd     = is_column(cmd.op) && open_vec[bank] && busy_vec[bank];
    end

    p_act_opens_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == CMD_ACT) |=> open_vec[$past(bank)]);

    p_pre_all_closes_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == CMD_PRE && cmd.all_banks) |=> (open_vec == '0));

    p_busy_needs_open_r5: assert property (@(posedge clk) disable iff (rst)
        ((busy_vec & ~open_vec) == '0));

endmodule

// File: rtl/sdram_mode_tracker.sv
module sdram_mode_tracker
    import sdram_mon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  cmd_t cmd,
    input  logic any_open,
    output logic v_act_nomode,
    output logic v_mrs_open,
    output logic v_mrs_cke,
    output logic v_mrs_next
);

    logic cke_q;
    logic mrs_q;
    logic mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q  <= 1'b0;
            mrs_q  <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            cke_q <= cke;
            mrs_q <= (cmd.op == CMD_MRS);
            if (cmd.op == CMD_MRS) begin
                mode_q <= 1'b1;
            end
        end
    end

    always_comb begin
        v_act_nomode = (cmd.op == CMD_ACT) && !mode_q;
        v_mrs_open   = (cmd.op == CMD_MRS) && any_open;
        v_mrs_cke    = (cmd.op == CMD_MRS) && !cke_q;
        v_mrs_next   = mrs_q && (cmd.op != CMD_NOP);
    end

    p_mode_kept_r10: assert property (@(posedge clk) disable iff (rst)
        mode_q |=> mode_q);

    p_mrs_programs_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == CMD_MRS) |=> mode_q);

    p_next_after_mrs_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == CMD_MRS) ##1 (cmd.op != CMD_NOP) |-> v_mrs_next);

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int TRCD      = 3,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [BA_W-1:0]  ba,
    input  logic             addr_all,
    output logic [ERR_W-1:0] err
);

    cmd_t             cmd;
    logic             any_open;
    logic             v_act_open;
    logic             v_col_idle;
    logic             v_trcd;
    logic             v_act_nomode;
    logic             v_mrs_open;
    logic             v_mrs_cke;
    logic             v_mrs_next;
    logic [ERR_W-1:0] viol;
    logic [ERR_W-1:0] err_q;

    sdram_cmd_decode u_decode (
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .addr_all (addr_all),
        .cmd      (cmd)
    );

    sdram_bank_tracker #(
        .NUM_BANKS (NUM_BANKS),
        .TRCD      (TRCD)
    ) u_banks (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .bank       (ba),
        .any_open   (any_open),
        .v_act_open (v_act_open),
        .v_col_idle (v_col_idle),
        .v_trcd     (v_trcd)
    );

    sdram_mode_tracker u_mode (
        .clk          (clk),
        .rst          (rst),
        .cke          (cke),
        .cmd          (cmd),
        .any_open     (any_open),
        .v_act_nomode (v_act_nomode),
        .v_mrs_open   (v_mrs_open),
        .v_mrs_cke    (v_mrs_cke),
        .v_mrs_next   (v_mrs_next)
    );

    always_comb begin
        viol                 = '0;
        viol[ERR_ACT_NOMODE] = v_act_nomode;
        viol[ERR_ACT_OPEN]   = v_act_open;
        viol[ERR_COL_IDLE]   = v_col_idle;
        viol[ERR_TRCD]       = v_trcd;
        viol[ERR_MRS_OPEN]   = v_mrs_open;
        viol[ERR_MRS_CKE]    = v_mrs_cke;
        viol[ERR_MRS_NEXT]   = v_mrs_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else begin
            err_q <= err_q | viol;
        end
    end

    assign err = err_q;

    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((err_q & $past(err_q)) == $past(err_q)));

endmodule

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb_top;

    localparam int NB    = 4;
    localparam int TRCDV = 3;

    localparam logic [2:0] P_NOP = 3'b111;
    localparam logic [2:0] P_ACT = 3'b011;
    localparam logic [2:0] P_RD  = 3'b101;
    localparam logic [2:0] P_WR  = 3'b100;
    localparam logic [2:0] P_PRE = 3'b010;
    localparam logic [2:0] P_REF = 3'b001;
    localparam logic [2:0] P_MRS = 3'b000;
    localparam logic [2:0] P_BST = 3'b110;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cke = 1'b0;
    logic       ras_n = 1'b1;
    logic       cas_n = 1'b1;
    logic       we_n = 1'b1;
    logic [1:0] ba = '0;
    logic       addr_all = 1'b0;
    logic [6:0] err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    sdram_cmd_monitor #(.NUM_BANKS(NB), .TRCD(TRCDV)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .cke      (cke),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .ba       (ba),
        .addr_all (addr_all),
        .err      (err)
    );

    // drives one command from a falling edge and returns at the next falling edge
    task automatic issue(input logic [2:0] pins, input int b, input logic all);
        {ras_n, cas_n, we_n} = pins;
        ba       = 2'(b);
        addr_all = all;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [6:0] exp);
        n_checks++;
        if (err !== exp) begin
            n_fail++;
            $display("FAIL %s err actual=%b expected=%b", req, err, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cke = 1'b0;
        {ras_n, cas_n, we_n} = P_NOP;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic init_mode();
        do_reset();
        cke = 1'b1;
        issue(P_NOP, 0, 0);
        issue(P_MRS, 0, 0);
        issue(P_NOP, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check("R11 reset state", 7'b0);

        // R2: activate without a programmed mode register
        cke = 1'b1;
        issue(P_NOP, 0, 0);
        issue(P_ACT, 0, 0);
        check("R2 act before mode write", 7'b0000001);
        issue(P_NOP, 0, 0);
        issue(P_NOP, 0, 0);
        check("R11 flag stays set", 7'b0000001);
        do_reset();
        check("R11 reset clears flags", 7'b0);

        // R7: cke low on the clock before the mode write
        cke = 1'b0;
        issue(P_NOP, 0, 0);
        cke = 1'b1;
        issue(P_MRS, 0, 0);
        issue(P_NOP, 0, 0);
        check("R7 mode write with cke low before", 7'b0100000);
        init_mode();
        check("R7 legal mode write", 7'b0);

        // R6: mode write with a bank open
        init_mode();
        issue(P_ACT, 2, 0);
        issue(P_NOP, 0, 0);
        issue(P_MRS, 0, 0);
        issue(P_NOP, 0, 0);
        check("R6 mode write with open bank", 7'b0010000);

        // R10: rewrite after precharge is legal, mode stays programmed
        init_mode();
        issue(P_ACT, 1, 0);
        issue(P_PRE, 1, 0);
        issue(P_MRS, 0, 0);
        issue(P_NOP, 0, 0);
        issue(P_ACT, 1, 0);
        check("R10 legal rewrite then activate", 7'b0);
        // R10: rewrite followed at once by an activate
        issue(P_PRE, 1, 0);
        issue(P_MRS, 0, 0);
        issue(P_ACT, 3, 0);
        check("R10 rewrite followed by activate", 7'b1000000);

        // R9 and R3: single bank precharge
        init_mode();
        issue(P_ACT, 0, 0);
        issue(P_ACT, 1, 0);
        issue(P_PRE, 0, 0);
        issue(P_ACT, 0, 0);
        check("R9 single precharge closes its bank", 7'b0);
        issue(P_ACT, 1, 0);
        check("R3 activate to open bank", 7'b0000010);

        // R9: precharge all
        init_mode();
        for (int b = 0; b < NB; b++) issue(P_ACT, b, 0);
        issue(P_PRE, 2, 1);
        issue(P_MRS, 0, 0);
        issue(P_NOP, 0, 0);
        for (int b = 0; b < NB; b++) issue(P_ACT, b, 0);
        check("R9 precharge all closes every bank", 7'b0);

        // R4: column to idle bank, read and write
        init_mode();
        issue(P_RD, 2, 0);
        check("R4 read to idle bank", 7'b0000100);
        init_mode();
        issue(P_ACT, 0, 0);
        issue(P_WR, 3, 0);
        check("R4 write to idle bank", 7'b0000100);

        // R5: activate-to-column gap sweep over every bank
        for (int b = 0; b < NB; b++) begin
            for (int k = 1; k <= 5; k++) begin
                logic [6:0] exp;
                init_mode();
                issue(P_ACT, b, 0);
                for (int j = 1; j < k; j++) issue(P_NOP, 0, 0);
                issue(((k % 2) == 1) ? P_RD : P_WR, b, 0);
                exp = (k < TRCDV) ? 7'b0001000 : 7'b0;
                check($sformatf("R5 bank %0d gap %0d", b, k), exp);
            end
        end

        // R8 and R1: every code in the clock after a mode write
        for (int c = 0; c < 8; c++) begin
            logic [2:0] pins;
            logic [6:0] exp;
            pins = 3'(c);
            init_mode();
            issue(P_MRS, 0, 0);
            issue(pins, 0, 0);
            if (pins == P_NOP)                      exp = 7'b0;
            else if (pins == P_RD || pins == P_WR)  exp = 7'b1000100;
            else                                    exp = 7'b1000000;
            check($sformatf("R8 R1 code %b after mode write", pins), exp);
        end

        // R1: refresh and burst stop leave the flags untouched
        init_mode();
        issue(P_REF, 0, 0);
        issue(P_BST, 1, 0);
        issue(P_NOP, 0, 0);
        check("R1 refresh and burst stop", 7'b0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R11 watchdog actual=timeout expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule